// File: doc/BRIEF.md
# Three-Wire Control Port Master Sequencer

This block runs single-byte register reads and writes on a three-wire serial control port, from the host side. It drives a frame strobe that is active low, a serial clock and a serial data line, and it samples a return data line. A request carries an operation type, a 4-bit register address, a write byte, a 3-bit module identifier and a clock divider value. The block is busy from the moment it accepts a request until it gives a one-cycle done pulse. On reads it also returns the captured byte.

Each transfer starts with an 18-bit command frame, sent while the strobe is low, with every field sent least significant bit first. A write ends right after that frame. A read goes on with a stand-alone latch clock pulse while the strobe is high. The strobe then drops again for eight readback clocks, with the data line held low. Strobe edges only ever happen while the serial clock is low. Every half-period of the serial clock, which this brief calls a slot, lasts N system clocks. N comes from the divider value.

Top module: `ctlp_master`

## Requirements
- R1: While idle, and in reset, frm_o is 1, sck_o is 0, sdo_o is 0, and busy_o and done_o are 0.
- R2: The command frame has 18 serial clocks, with frm_o low. During clock k, sdo_o carries frame bit k. Bits 0-7 are the data byte, LSB first. Bits 8-11 are req_addr_i[0] to req_addr_i[3]. Bits 12-13 are 0. Bit 14 is R/W. Bits 15-17 are req_mod_i[0] to req_mod_i[2].
- R3: On a read (req_write_i=0), R/W is 0 and all eight data bits are sent as 0, whatever req_wdata_i holds. On a write, R/W is 1.
- R4: sdo_o never changes while sck_o is high. Each clock consists of a low slot followed by a high slot.
- R5: frm_o changes only in a cycle where sck_o is low and was also low in the cycle before.
- R6: A read continues after the frame with these slots in order: one slot with frm_o low and sck_o low, then frm_o high with sck_o low, then a single high latch slot, then a low slot with frm_o still high, and then frm_o falls with sck_o low.
- R7: A read then issues 8 readback clocks with frm_o low, followed by one low slot. sdo_o stays 0 from the latch pulse to the end of the operation.
- R8: sdi_i is sampled in the last system cycle of each readback high slot, least significant bit first. rdata_o holds the assembled byte in the done cycle.
- R9: Every slot lasts N system cycles. N is req_div_i as sampled at acceptance, with values below 2 taken as 2. A later change of req_div_i has no effect on the running operation.
- R10: A request is accepted only while busy_o is 0. busy_o stays high from acceptance through the done cycle. done_o is high for exactly one cycle. Requests made while busy are ignored.
- R11: A write consists of the 18 frame clocks, then one low slot, then frm_o rises. It has no latch pulse and no readback phase, so it takes 37·N cycles plus the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Register address |
| req_wdata_i | input | 8 | Write byte |
| req_mod_i | input | 3 | Module identifier |
| req_div_i | input | DIV_W | Slot length in system cycles |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read byte, valid in the done cycle of a read |
| frm_o | output | 1 | Frame strobe, active low |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the port |
| sdi_i | input | 1 | Serial return data |

## Verification
The assertions check several rules on every cycle. Idle pins stay quiet. The data line is stable during high clock slots. Strobe edges fall only inside low clock time. The data line stays low through readback. A write never raises the strobe mid-operation. The done pulse is single and always occurs while busy_o is high. Other behaviours can only be shown by the bench's scenarios, which compare every cycle against a waveform model. These are the bit order of the frame, the zeroed placeholders, the exact latch sequence, the captured byte order, the slot length and divider clamping, and the ignoring of requests and divider changes while busy.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int ADDR_FW = 6;
  localparam int MOD_W   = 3;
  localparam int FRAME_W = DATA_W + ADDR_FW + 1 + MOD_W;
  localparam int RD_BITS = 8;
  localparam int SLOT_W  = 6;

  // slot map, one slot = one serial clock half-period
  localparam logic [SLOT_W-1:0] SL_SETTLE = SLOT_W'(2 * FRAME_W);
  localparam logic [SLOT_W-1:0] SL_LUP    = SL_SETTLE + 1'b1;
  localparam logic [SLOT_W-1:0] SL_LHI    = SL_SETTLE + 2'd2;
  localparam logic [SLOT_W-1:0] SL_LLO    = SL_SETTLE + 2'd3;
  localparam logic [SLOT_W-1:0] SL_RD0    = SL_SETTLE + 3'd4;
  localparam logic [SLOT_W-1:0] SL_RDH    = SL_RD0 + SLOT_W'(2 * RD_BITS - 1);
  localparam logic [SLOT_W-1:0] SL_RDEND  = SL_RDH + 1'b1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;

  typedef struct packed {
    logic frm;
    logic sck;
    logic sdo;
  } pins_t;
endpackage

// File: rtl/ctlp_tick.sv
module ctlp_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ctlp_frame.sv
module ctlp_frame
  import ctlp_pkg::*;
(
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [MOD_W-1:0]  mod_i,
  output logic [FRAME_W-1:0] frame_o
);
  // bit 0 leaves first; read data bits are zero placeholders
  assign frame_o = {mod_i, write_i, {(ADDR_FW-ADDR_W){1'b0}}, addr_i,
                    write_i ? wdata_i : {DATA_W{1'b0}}};
endmodule

// File: rtl/ctlp_rx_shift.sv
module ctlp_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      byte_o <= '0;
    else if (shift_i) byte_o <= {bit_i, byte_o[W-1:1]};
  end
endmodule

// File: rtl/ctlp_master.sv
module ctlp_master
  import ctlp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [3:0]        req_addr_i,
  input  logic [7:0]        req_wdata_i,
  input  logic [2:0]        req_mod_i,
  input  logic [DIV_W-1:0]  req_div_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        rdata_o,
  output logic              frm_o,
  output logic              sck_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  localparam pins_t PINS_IDLE = '{frm: 1'b1, sck: 1'b0, sdo: 1'b0};

  st_e                st_q;
  logic [SLOT_W-1:0]  slot_q;
  logic               wr_q;
  logic [FRAME_W-1:0] frame_q, frame_w;
  logic [DIV_W-1:0]   div_q;
  pins_t              pins_q;
  logic               tick, accept, last_slot, rx_shift;

  function automatic pins_t slot_pins(input logic [SLOT_W-1:0] s,
                                      input logic [FRAME_W-1:0] f);
    pins_t p;
    p = '{frm: 1'b0, sck: 1'b0, sdo: 1'b0};
    if (s < SL_SETTLE) begin
      p.sck = s[0];
      p.sdo = f[s[SLOT_W-1:1]];
    end else if (s >= SL_LUP && s <= SL_LLO) begin
      p.frm = 1'b1;
      p.sck = (s == SL_LHI);
    end else if (s >= SL_RD0 && s <= SL_RDH) begin
      p.sck = s[0];
    end
    return p;
  endfunction

  ctlp_frame u_frame (
    .write_i (req_write_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .mod_i   (req_mod_i),
    .frame_o (frame_w)
  );

  ctlp_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q == ST_RUN),
    .div_i  (div_q),
    .tick_o (tick)
  );

  assign accept    = req_valid_i && (st_q == ST_IDLE);
  assign last_slot = wr_q ? (slot_q == SL_SETTLE) : (slot_q == SL_RDEND);
  // sample just before each readback falling edge
  assign rx_shift  = tick && !wr_q && slot_q[0] &&
                     (slot_q >= SL_RD0) && (slot_q <= SL_RDH);

  ctlp_rx_shift #(.W(RD_BITS)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (rx_shift),
    .bit_i   (sdi_i),
    .byte_o  (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      slot_q  <= '0;
      wr_q    <= 1'b0;
      frame_q <= '0;
      div_q   <= DIV_W'(2);
      pins_q  <= PINS_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_RUN;
          slot_q  <= '0;
          wr_q    <= req_write_i;
          frame_q <= frame_w;
          div_q   <= (req_div_i < DIV_W'(2)) ? DIV_W'(2) : req_div_i;
          pins_q  <= slot_pins('0, frame_w);
        end
        ST_RUN: if (tick) begin
          if (last_slot) begin
            st_q   <= ST_DONE;
            pins_q <= PINS_IDLE;
          end else begin
            slot_q <= slot_q + 1'b1;
            pins_q <= slot_pins(slot_q + 1'b1, frame_q);
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_DONE);
  assign frm_o  = pins_q.frm;
  assign sck_o  = pins_q.sck;
  assign sdo_o  = pins_q.sdo;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (frm_o && !sck_o && !sdo_o && !done_o)); // R1
  AST_SDO_HOLD_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(sdo_o)); // R4
  AST_FRM_EDGE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frm_o) |-> (!sck_o && !$past(sck_o))); // R5
  AST_RD_SDO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !wr_q && slot_q >= SL_SETTLE) |-> !sdo_o); // R7
  AST_DIV_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (div_q >= DIV_W'(2))); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R10
  AST_WR_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && wr_q) |-> !frm_o); // R11
endmodule

// File: tb/ctlp_master_tb.sv
module ctlp_master_tb_top;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [2:0] req_mod = '0;
  logic [DIV_W-1:0] req_div = '0;
  logic busy, done, frm, sck, sdo, sdi = 1'b0;
  logic [7:0] rdata;

  always #5 clk = ~clk;

  ctlp_master #(.DIV_W(DIV_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_mod_i(req_mod),
    .req_div_i(req_div), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .frm_o(frm), .sck_o(sck), .sdo_o(sdo), .sdi_i(sdi));

  typedef struct {
    bit frm, sck, sdo, busy, done, chk;
    bit [7:0] rd;
    int tag;
  } exp_t;

  exp_t q[$];
  int errors = 0, checks = 0, cyc = 0;
  bit m_busy = 0;
  bit [7:0] resp = '0;
  bit latch_seen = 0;
  int idx = 0;
  bit p_sck = 0, p_sdo = 0, p_frm = 1;

  function automatic void put(bit f, bit c, bit d, int n, int tag);
    for (int i = 0; i < n; i++) q.push_back('{f, c, d, 1'b1, 1'b0, 1'b0, 8'h00, tag});
  endfunction

  // waveform model built from the requirements
  function automatic void model_op();
    int n;
    bit [17:0] fr;
    n = (req_div < 2) ? 2 : int'(req_div);               // R9
    for (int b = 0; b < 8; b++) fr[b] = req_write ? req_wdata[b] : 1'b0; // R3
    for (int b = 0; b < 4; b++) fr[8+b] = req_addr[b];   // R2
    fr[12] = 0; fr[13] = 0;
    fr[14] = req_write;
    for (int b = 0; b < 3; b++) fr[15+b] = req_mod[b];
    for (int s = 0; s < 36; s++) put(0, s[0], fr[s/2], n, (s/2 < 8 || s/2 == 14) ? 3 : 2);
    put(0, 0, 0, n, req_write ? 11 : 6);
    if (!req_write) begin
      put(1, 0, 0, n, 6); put(1, 1, 0, n, 6); put(1, 0, 0, n, 6);   // R6
      for (int k = 0; k < 8; k++) begin put(0, 0, 0, n, 7); put(0, 1, 0, n, 7); end // R7
      put(0, 0, 0, n, 7);
    end
    q.push_back('{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, !req_write, resp, 10});
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst_ni && req_valid && !m_busy) model_op();      // R10 accept rule
  end

  task automatic fail(int tag, string what, int act, int expv);
    errors++;
    $display("FAIL R%0d %s: actual=%0h expected=%0h (t=%0t)", tag, what, act, expv, $time);
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) e = q.pop_front();
    else e = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1}; // R1 idle
    m_busy = e.busy;
    checks++;
    if ({frm, sck, sdo, busy, done} !== {e.frm, e.sck, e.sdo, e.busy, e.done})
      fail(e.tag, "pins{frm,sck,sdo,busy,done}", {frm, sck, sdo, busy, done},
           {e.frm, e.sck, e.sdo, e.busy, e.done});
    if (e.chk) begin
      checks++;
      if (rdata !== e.rd) fail(8, "rdata", rdata, e.rd);  // R8
    end
    checks++;
    if (p_sck && sck && sdo !== p_sdo) fail(4, "sdo moved while sck high", sdo, p_sdo); // R4
    checks++;
    if (frm !== p_frm && (sck || p_sck)) fail(5, "frm edge with sck high", sck, 0);    // R5
    // return-line slave: bit k valid across readback clock k
    if (frm && sck) begin latch_seen = 1; idx = 0; end
    else if (latch_seen && !frm && p_sck && !sck) idx++;
    if (!busy) latch_seen = 0;
    sdi = (latch_seen && idx < 8) ? resp[idx] : 1'b0;
    p_sck = sck; p_sdo = sdo; p_frm = frm;
  end

  always @(posedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  task automatic issue(bit wr, bit [3:0] a, bit [7:0] d, bit [2:0] m, bit [7:0] dv, bit [7:0] r);
    @(posedge clk); #2;
    resp = r; req_write = wr; req_addr = a; req_wdata = d; req_mod = m; req_div = dv;
    req_valid = 1;
    @(posedge clk); #2;
    req_valid = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);                          // R1 checked during reset
    #2 rst_ni = 1;
    repeat (4) @(posedge clk);
    issue(1, 4'h5, 8'hA5, 3'b011, 8'd2, 8'h00); wait_done();   // R2 R11 write
    issue(0, 4'hF, 8'h00, 3'b011, 8'd3, 8'hB1); wait_done();   // R6 R7 R8 read
    issue(0, 4'h9, 8'hFF, 3'b101, 8'd0, 8'h4E); wait_done();   // R3 placeholders, R9 clamp
    issue(1, 4'h0, 8'h3C, 3'b110, 8'd4, 8'h00); wait_done();   // R3 R/W=1, R9 N=4
    // R10 ignored requests and R9 divider change while busy
    issue(0, 4'h2, 8'h00, 3'b001, 8'd2, 8'h96);
    repeat (7) @(posedge clk);
    #2 req_valid = 1; req_write = 1; req_addr = 4'hC; req_div = 8'd7; resp = 8'h96;
    repeat (5) @(posedge clk);
    #2 req_valid = 0;
    wait_done();
    // R10 back-to-back: held request re-accepted only after done
    @(posedge clk); #2;
    resp = 8'h01; req_write = 0; req_addr = 4'h7; req_mod = 3'b011; req_div = 8'd1;
    req_valid = 1;
    do @(negedge clk); while (!done);
    do @(negedge clk); while (!busy);
    @(posedge clk); #2 req_valid = 0;
    wait_done();
    repeat (5) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule